// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets a host read and write registers inside external Ethernet PHYs over the two-wire management bus. The bus has a clock line (MDC) and a bidirectional data line (MDIO). The host first programs a control word. That word turns the controller on and sets the MDC rate through an 8-bit divider. The host then writes one command word that names the PHY, the register, the direction and, for a write, the data. Setting the go bit in that same command word starts the whole serial transaction. The go bit stays high as a busy flag until the last frame bit has been clocked, and then it clears by itself. For a read, the value the PHY returned replaces the data field of the command word.

The controller also records which PHY addresses have answered. A PHY answers a read by pulling MDIO low in the second turnaround bit. Each answer sets that address's bit in a 32-bit presence map, and the bit stays set until reset. Software can read this map to find out which PHYs are fitted.

The host side is a simple register port. A write takes effect on the clock edge where `reg_we` is high. Read data is combinational from `reg_addr`. The MDIO pad is split into an output value, an output enable and an input.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset, the control word reads 0x8000_0000 (idle set, disabled, divider 0), the command word reads 0, the presence map reads 0, and `mdc` and `mdio_oe` are low.
- R2: The host register addresses are as follows. Address 0 is the control word: bit 31 is idle (read-only, the inverse of busy), bit 30 is enable, and bits 7:0 are the divider. Address 1 is the command word: bit 31 is go/busy, bit 30 is write (1) or read (0), bits 25:21 are the register number, bits 20:16 are the PHY address, and bits 15:0 are the data. Address 2 is the presence map, which is read-only, and writes to it have no effect.
- R3: A command write with go=1 starts a transaction only when enable is 1. With enable at 0, the fields are stored, busy stays 0 and MDC does not toggle.
- R4: A command write that arrives while busy is 1 is ignored. The stored fields are unchanged and the running transaction is not restarted.
- R5: During a transaction, MDC is high for div+1 clocks and low for div+1 clocks, and it produces exactly 64 rising edges. MDC rests low when idle.
- R6: The frame sends 32 ones, then start 01, then opcode 10 for a read or 01 for a write, then the PHY address and the register number MSB first, then 2 turnaround bits, then 16 data bits MSB first. A write sends turnaround 10.
- R7: MDIO changes only when MDC falls, or at the start while MDC is low. MDIO is stable at every MDC rising edge, and the PHY's bits are sampled there.
- R8: A write drives `mdio_oe` for all 64 bits. A read drives it for the first 46 bits only and releases the line for the turnaround and data bits. `mdio_oe` is low when idle.
- R9: Busy clears at the MDC fall that ends bit 63. After a read, bits 15:0 hold the 16 bits sampled from MDIO, MSB first. After a write, they keep the written data.
- R10: When a read samples MDIO low in the second turnaround bit, the bit in the presence map for that PHY address is set. Presence bits are never cleared, except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Value seen on MDIO |

## Verification
The assertions check the following on every cycle:
- MDC toggles only when the divider counter wraps, and rests low while idle.
- The frame position advances only on an MDC fall.
- A transaction can begin only while the controller is enabled.
- A busy command write leaves the stored fields unchanged.
- The output enable is low when idle.
- Presence bits never clear.

The bench scenarios cover what a property cannot: the exact frame bit pattern for each direction, the released turnaround and data bits, the half-period length for several divider values, the data returned from an emulated PHY, and whether silent PHYs leave the presence map alone.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
    // Frame geometry of the management bus (protocol-fixed)
    localparam int FRAME_BITS = 64;
    localparam int LAST_IDX   = FRAME_BITS - 1;
    localparam int HDR_BITS   = 46;           // preamble..register number
    localparam int TA2_IDX    = HDR_BITS + 1; // second turnaround bit
    localparam int DATA_START = HDR_BITS + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int ADR_W      = 5;
    localparam int DAT_W      = 16;

    // Host register addresses and bit positions (software-visible)
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_ACCESS = 2'd1;
    localparam logic [1:0] ADDR_ALIVE  = 2'd2;
    localparam int BIT_GO   = 31;
    localparam int BIT_WR   = 30;
    localparam int BIT_EN   = 30;
    localparam int REG_LSB  = 21;
    localparam int PHY_LSB  = 16;

    typedef struct packed {
        logic               wr;
        logic [ADR_W-1:0]   regad;
        logic [ADR_W-1:0]   phyad;
        logic [DAT_W-1:0]   data;
    } cmd_t;
endpackage

// File: rtl/mdc_divider.sv
`timescale 1ns/1ps
module mdc_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_q, st_d;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = run_i && (st_q.cnt >= div_i);
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = wrap && !st_q.mdc;
    assign fall_o = wrap &&  st_q.mdc;

    // MDC changes level only on a counter wrap (half period = div+1)
    assert_mdc_wrap_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mdc != $past(st_q.mdc)) |-> $past(wrap));
    // Clock rests low whenever the engine is idle
    assert_mdc_rest_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.mdc);
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
    import mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  cmd_t             cmd_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             mdio_i,
    output logic             busy_o,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done_o,
    output logic             hit_o,
    output logic [DAT_W-1:0] rdata_o
);
    typedef struct packed {
        logic                  busy;
        logic                  wr;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sr;
        logic [DAT_W-1:0]      rdata;
        logic                  hit;
        logic                  done;
    } sh_st_t;

    sh_st_t st_q, st_d;

    function automatic logic [FRAME_BITS-1:0] build_frame(input cmd_t c);
        return {{32{1'b1}}, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phyad, c.regad,
                (c.wr ? 2'b10 : 2'b11), (c.wr ? c.data : {DAT_W{1'b1}})};
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.wr    = cmd_i.wr;
                st_d.idx   = '0;
                st_d.sr    = build_frame(cmd_i);
                st_d.rdata = '0;
            end
        end else begin
            if (rise_i && !st_q.wr) begin
                if (st_q.idx == IDX_W'(TA2_IDX) && !mdio_i)
                    st_d.hit = 1'b1;
                if (st_q.idx >= IDX_W'(DATA_START))
                    st_d.rdata = {st_q.rdata[DAT_W-2:0], mdio_i};
            end
            if (fall_i) begin
                if (st_q.idx == IDX_W'(LAST_IDX)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sr  = {st_q.sr[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign mdio_o  = st_q.busy ? st_q.sr[FRAME_BITS-1] : 1'b0;
    assign mdio_oe = st_q.busy && (st_q.wr || st_q.idx < IDX_W'(HDR_BITS));
    assign done_o  = st_q.done;
    assign hit_o   = st_q.hit;
    assign rdata_o = st_q.rdata;

    // Frame position moves on to the next bit only after an MDC fall
    assert_advance_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy) && st_q.idx != $past(st_q.idx)) |-> $past(fall_i));
endmodule

// File: rtl/phy_mgmt_master.sv
`timescale 1ns/1ps
module phy_mgmt_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int PHY_CNT = 1 << ADR_W;

    typedef struct packed {
        logic               en;
        logic [DIV_W-1:0]   div;
        cmd_t               cmd;
        logic [PHY_CNT-1:0] alive;
    } regs_t;

    regs_t            r_q, r_d;
    logic             go;
    logic             busy, done, hit, rise, fall;
    logic [DAT_W-1:0] rdata;
    logic             wdata_unused;

    assign wdata_unused = ^{reg_wdata[29:26], reg_wdata[31:DIV_W]};

    always_comb begin
        r_d = r_q;
        go  = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    r_d.en  = reg_wdata[BIT_EN];
                    r_d.div = reg_wdata[DIV_W-1:0];
                end
                ADDR_ACCESS: begin
                    if (!busy) begin
                        r_d.cmd.wr    = reg_wdata[BIT_WR];
                        r_d.cmd.regad = reg_wdata[REG_LSB +: ADR_W];
                        r_d.cmd.phyad = reg_wdata[PHY_LSB +: ADR_W];
                        r_d.cmd.data  = reg_wdata[DAT_W-1:0];
                        go            = reg_wdata[BIT_GO] && r_q.en;
                    end
                end
                default: ;
            endcase
        end
        if (done && !r_q.cmd.wr)
            r_d.cmd.data = rdata;
        if (hit)
            r_d.alive[r_q.cmd.phyad] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {~busy, r_q.en, {(30-DIV_W){1'b0}}, r_q.div};
            ADDR_ACCESS: reg_rdata = {busy, r_q.cmd.wr, 4'b0, r_q.cmd.regad,
                                      r_q.cmd.phyad, r_q.cmd.data};
            ADDR_ALIVE:  reg_rdata = r_q.alive;
            default:     reg_rdata = '0;
        endcase
    end

    mdc_divider #(.DIV_W(DIV_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (r_q.div),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_shifter i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go),
        .cmd_i   (r_d.cmd),
        .rise_i  (rise),
        .fall_i  (fall),
        .mdio_i  (mdio_i),
        .busy_o  (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done_o  (done),
        .hit_o   (hit),
        .rdata_o (rdata)
    );

    // A transaction only begins while the controller is enabled
    assert_start_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.en));
    // Command writes during a transaction leave the stored fields untouched
    assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == ADDR_ACCESS && !done)
            |=> (r_q.cmd.regad == $past(r_q.cmd.regad) && r_q.cmd.phyad == $past(r_q.cmd.phyad)
                 && r_q.cmd.wr == $past(r_q.cmd.wr)));
    // Line is never driven while idle
    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // Presence bits are sticky
    assert_alive_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.alive & $past(r_q.alive)) == $past(r_q.alive));
endmodule

// File: tb/test_phy_mgmt_master.sv
`timescale 1ns/1ps
module test_phy_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_checks = 0;
    int n_fail   = 0;
    int rise_cnt = 0;
    bit finished = 0;
    logic [31:0] alive_model = '0;

    always #5 clk = ~clk;
    always @(posedge mdc) rise_cnt++;

    phy_mgmt_master i_phy_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_read(2'd1, v);
            if (!v[31]) break;
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                               input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
                (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
    endfunction

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, input bit respond, input logic [15:0] pval,
                           input logic [7:0] div);
        logic [63:0] cap, capoe, ef;
        logic [31:0] v;
        logic        after_fall;
        time         t_r, t_f;
        int          hp_err, stab_err, r0;
        logic [15:0] exp_d;
        hp_err = 0; stab_err = 0; t_r = 0;
        reg_write(2'd0, {2'b01, 22'b0, div});
        r0 = rise_cnt;
        reg_write(2'd1, {1'b1, wr, 4'b0, ra, phy, d});
        for (int k = 0; k < 64; k++) begin
            if (k > 0) begin
                @(negedge mdc);
                t_f = $time;
                if (t_f - t_r != (div + 1) * 10) hp_err++;
            end
            #1;
            if (!wr && respond && k == 47)      mdio_i = 1'b0;
            else if (!wr && respond && k >= 48) mdio_i = pval[63-k];
            else                                mdio_i = 1'b1;
            after_fall = mdio_o;
            @(posedge mdc);
            t_r = $time;
            #1;
            cap[63-k]   = mdio_o;
            capoe[63-k] = mdio_oe;
            if (mdio_o !== after_fall) stab_err++;
        end
        @(negedge mdc);
        t_f = $time;
        if (t_f - t_r != (div + 1) * 10) hp_err++;
        mdio_i = 1'b1;
        repeat (3) @(negedge clk);
        ef = exp_frame(wr, phy, ra, d);
        check(hp_err == 0, "R5 half period", hp_err, 0);
        check(rise_cnt - r0 == 64 && mdc == 1'b0, "R5 rise count", rise_cnt - r0, 64);
        check(stab_err == 0, "R7 change only on fall", stab_err, 0);
        if (wr) begin
            check(cap == ef, "R6 write frame", cap, ef);
            check(capoe == '1, "R8 write drives all", capoe, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            check(cap[63:18] == ef[63:18], "R6 read header", cap[63:18], ef[63:18]);
            check(capoe == {{46{1'b1}}, 18'b0}, "R8 read release", capoe, {{46{1'b1}}, 18'b0});
            if (respond) alive_model[phy] = 1'b1;
        end
        exp_d = wr ? d : (respond ? pval : 16'hFFFF);
        reg_read(2'd1, v);
        check(v == {1'b0, wr, 4'b0, ra, phy, exp_d}, "R9 completion readback", v,
              {1'b0, wr, 4'b0, ra, phy, exp_d});
        reg_read(2'd2, v);
        check(v == alive_model, "R10 presence map", v, alive_model);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int r0;
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; mdio_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); check(v == 32'h8000_0000, "R1 control reset", v, 32'h8000_0000);
        reg_read(2'd1, v); check(v == 32'h0, "R1 command reset", v, 0);
        reg_read(2'd2, v); check(v == 32'h0, "R1 presence reset", v, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {mdc, mdio_oe}, 0);

        // R2 control readback, presence map read-only
        reg_write(2'd0, 32'h4000_0005);
        reg_read(2'd0, v); check(v == 32'hC000_0005, "R2 control readback", v, 32'hC000_0005);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, v); check(v == 32'h0, "R2 presence read-only", v, 0);

        // R3 go with controller disabled
        reg_write(2'd0, 32'h0000_0001);
        r0 = rise_cnt;
        reg_write(2'd1, {1'b1, 1'b1, 4'b0, 5'd6, 5'd2, 16'h1357});
        repeat (40) @(negedge clk);
        reg_read(2'd1, v);
        check(v == {1'b0, 1'b1, 4'b0, 5'd6, 5'd2, 16'h1357}, "R3 disabled no start", v,
              {1'b0, 1'b1, 4'b0, 5'd6, 5'd2, 16'h1357});
        check(rise_cnt == r0 && mdc == 1'b0, "R3 no MDC when disabled", rise_cnt - r0, 0);

        // Directed transactions
        run_txn(1'b1, 5'd3, 5'd4, 16'hA5C3, 1'b1, 16'h0, 8'd0);
        run_txn(1'b0, 5'd5, 5'd1, 16'h0, 1'b1, 16'h1234, 8'd2);
        run_txn(1'b0, 5'd9, 5'd31, 16'h0, 1'b0, 16'h0, 8'd1);
        run_txn(1'b0, 5'd31, 5'd0, 16'h0, 1'b1, 16'h8001, 8'd0);

        // R4 command write while busy
        reg_write(2'd0, 32'h4000_0001);
        r0 = rise_cnt;
        reg_write(2'd1, {1'b1, 1'b0, 4'b0, 5'd2, 5'd7, 16'h0});
        repeat (30) @(negedge clk);
        reg_write(2'd1, {1'b1, 1'b1, 4'b0, 5'd9, 5'd12, 16'hBEEF});
        wait_idle();
        reg_read(2'd1, v);
        check(v == {1'b0, 1'b0, 4'b0, 5'd2, 5'd7, 16'hFFFF}, "R4 busy write ignored", v,
              {1'b0, 1'b0, 4'b0, 5'd2, 5'd7, 16'hFFFF});
        check(rise_cnt - r0 == 64, "R4 no restart", rise_cnt - r0, 64);

        // Random transactions
        for (int i = 0; i < 8; i++) begin
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    1'($urandom), 16'($urandom), 8'($urandom % 4));
        end

        reg_read(2'd0, v); check(v[31] == 1'b1, "R9 idle after traffic", v[31], 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule